// File: doc/BRIEF.md
# Hot-plug card slot power state controller

This controller decides which supply groups a removable card slot receives. The auxiliary group is a single 3.3 V rail. The primary group is the 3.3 V and 1.5 V rails, which switch together. The decision uses four inputs: a system-active level, two active-low card-present pins (one for a PCIe-style card, one for a USB-style card) and a master enable. These pins arrive from the board without timing relation to the clock. Each one is resynchronised and debounced before a small state machine uses it.

The slot's history matters when the system is in standby. A card that was powered while the system was active keeps its auxiliary rail after the drop to standby. A card inserted during standby receives nothing until the system becomes active again. Removing a card in standby also leaves the slot dark until the system returns to active.

Under-voltage flags for each supply input and an over-temperature flag come from on-chip monitors as synchronous digital levels. They override the state machine and force the affected switches open. Each rail group has an enable output and a discharge request output. A group's discharge request is asserted whenever that group is switched off.

Top module: `slot_pwr_ctrl`

## Requirements
- R1: After reset both enables (`aux_en_o`, `main_en_o`) are 0 and both discharge requests (`aux_dis_o`, `main_dis_o`) are 1. Every rail group that is off has its discharge request at 1; every group that is on has it at 0.
- R2: A card counts as present when `pcie_present_n_i` is 0, or `usb_present_n_i` is 0, or both (0 = card present). With the system active (`sys_active_i` = 1) and no card present, both groups are off.
- R3: With the system active and a card present on either pin, both the auxiliary and the primary groups are on.
- R4: When the system goes from active to standby (`sys_active_i` = 0) while a card stays present, the auxiliary group stays on and the primary group turns off.
- R5: A card inserted while the system is in standby gets no power for as long as standby lasts.
- R6: Removing the card while the auxiliary group is on in standby turns every group off. Re-inserting a card before the system becomes active again leaves every group off.
- R7: While `master_en_i` is 0, every group is off and both discharge requests are 1, whatever the other inputs show.
- R8: While `uv_aux_i` is 1 the auxiliary group is off; the primary group is unaffected.
- R9: While `uv_p3_i` or `uv_p15_i` is 1 the primary group is off, unless `test_strap_i` is 1, in which case both flags are ignored.
- R10: While `over_temp_i` is 1 every group is off.
- R11: A change on any of the four control pins takes effect only after the pin has held its new level for `DEB_CYCLES` consecutive clocks after the two-flop synchroniser. A shorter pulse has no effect on the outputs.
- R12: Returning from standby to active with a card present turns both groups on, whatever the standby history was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_active_i | input | 1 | System status, 1 = active, 0 = standby (asynchronous) |
| pcie_present_n_i | input | 1 | PCIe-style card present, active low (asynchronous) |
| usb_present_n_i | input | 1 | USB-style card present, active low (asynchronous) |
| master_en_i | input | 1 | Master enable, 0 opens all switches (asynchronous) |
| test_strap_i | input | 1 | 1 = ignore primary under-voltage flags |
| uv_aux_i | input | 1 | Under-voltage on the auxiliary supply input |
| uv_p3_i | input | 1 | Under-voltage on the primary 3.3 V supply input |
| uv_p15_i | input | 1 | Under-voltage on the primary 1.5 V supply input |
| over_temp_i | input | 1 | Over-temperature flag |
| aux_en_o | output | 1 | Auxiliary 3.3 V switch enable |
| main_en_o | output | 1 | Primary 3.3 V and 1.5 V switch enable |
| aux_dis_o | output | 1 | Auxiliary output discharge request |
| main_dis_o | output | 1 | Primary outputs discharge request |

## Verification
Directed sequences cover standby entry with a card already powered, insertion during standby, and removal followed by re-insertion in standby. Together they separate a controller that remembers history from one that only reads the present input levels. Each presence pin is also driven on its own, to show that either pin counts as a card. Short pulses and a sampled latency window show whether debouncing actually filters. Each fault flag is set alone, and the primary flags are also set with the test strap high, to show that each flag reaches only its own rail group. Random sequences of all inputs are then compared against a reference model that tracks whether the card was powered before standby.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    typedef enum logic [2:0] {
        SL_OFF       = 3'd0,
        SL_ACT_EMPTY = 3'd1,
        SL_ACT_FULL  = 3'd2,
        SL_STBY_HOLD = 3'd3,
        SL_STBY_DARK = 3'd4
    } slot_state_e;

    // conditioned control pins, MSB first
    typedef struct packed {
        logic sys_up;
        logic pcie_n;
        logic usb_n;
        logic enable;
    } ctl_t;

    typedef struct packed {
        logic uv_aux;
        logic uv_p3;
        logic uv_p15;
        logic hot;
        logic test_strap;
    } fault_t;

    typedef struct packed {
        logic aux_on;
        logic main_on;
    } rail_req_t;

    localparam int NUM_CTL = $bits(ctl_t);
    // reset levels: standby, no cards, disabled
    localparam ctl_t CTL_RESET = '{sys_up: 1'b0, pcie_n: 1'b1, usb_n: 1'b1, enable: 1'b0};

    function automatic logic card_seen(ctl_t c);
        return !c.pcie_n || !c.usb_n;
    endfunction

    function automatic slot_state_e next_slot(slot_state_e s, ctl_t c);
        logic card;
        card = card_seen(c);
        if (!c.enable)
            return SL_OFF;
        if (c.sys_up)
            return card ? SL_ACT_FULL : SL_ACT_EMPTY;
        if (card && (s == SL_ACT_FULL || s == SL_STBY_HOLD))
            return SL_STBY_HOLD;
        return SL_STBY_DARK;
    endfunction

    function automatic rail_req_t state_rails(slot_state_e s);
        rail_req_t r;
        r.aux_on  = (s == SL_ACT_FULL) || (s == SL_STBY_HOLD);
        r.main_on = (s == SL_ACT_FULL);
        return r;
    endfunction

endpackage

// File: rtl/ctl_debounce.sv
module ctl_debounce #(
    parameter int   DEB_CYCLES = 8,
    parameter logic RST_VAL    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic          s1_q, s2_q, stable_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= RST_VAL;
            s2_q     <= RST_VAL;
            stable_q <= RST_VAL;
            cnt_q    <= '0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            if (s2_q == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                stable_q <= s2_q;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign clean_o = stable_q;

    // R11
    deb_settle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stable_q) |-> ($past(cnt_q) == LAST) && ($past(s2_q) != $past(stable_q)));

endmodule

// File: rtl/input_cond.sv
module input_cond
    import slot_pwr_pkg::*;
#(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t raw_i,
    output ctl_t clean_o
);
    logic [NUM_CTL-1:0] raw_vec;
    logic [NUM_CTL-1:0] clean_vec;
    localparam logic [NUM_CTL-1:0] RST_VEC = CTL_RESET;

    assign raw_vec = raw_i;

    for (genvar i = 0; i < NUM_CTL; i++) begin : g_pin
        ctl_debounce #(
            .DEB_CYCLES (DEB_CYCLES),
            .RST_VAL    (RST_VEC[i])
        ) u_deb (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_vec[i]),
            .clean_o (clean_vec[i])
        );
    end

    assign clean_o = ctl_t'(clean_vec);

endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
    import slot_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ctl_t        ctl_i,
    output slot_state_e state_o
);
    slot_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SL_OFF;
        else
            state_q <= next_slot(state_q, ctl_i);
    end

    assign state_o = state_q;

    // R5
    dark_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SL_STBY_DARK && ctl_i.enable && !ctl_i.sys_up) |=> (state_q == SL_STBY_DARK));

    // R7
    off_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.enable |=> (state_q == SL_OFF));

    // R4
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SL_STBY_HOLD) |-> ($past(state_q) == SL_ACT_FULL || $past(state_q) == SL_STBY_HOLD));

endmodule

// File: rtl/rail_gate.sv
module rail_gate
    import slot_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  slot_state_e state_i,
    input  fault_t      flt_i,
    output logic        aux_en_o,
    output logic        main_en_o,
    output logic        aux_dis_o,
    output logic        main_dis_o
);
    rail_req_t req;
    logic      aux_block, main_block;
    logic      aux_en_q, main_en_q;

    assign req        = state_rails(state_i);
    assign aux_block  = flt_i.hot | flt_i.uv_aux;
    assign main_block = flt_i.hot | ((flt_i.uv_p3 | flt_i.uv_p15) & ~flt_i.test_strap);

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_en_q  <= 1'b0;
            main_en_q <= 1'b0;
        end else begin
            aux_en_q  <= req.aux_on  & ~aux_block;
            main_en_q <= req.main_on & ~main_block;
        end
    end

    assign aux_en_o   = aux_en_q;
    assign main_en_o  = main_en_q;
    assign aux_dis_o  = ~aux_en_q;
    assign main_dis_o = ~main_en_q;

    // R10
    hot_off_chk: assert property (@(posedge clk) disable iff (rst)
        flt_i.hot |=> (!aux_en_o && !main_en_o));

    // R8
    uv_aux_off_chk: assert property (@(posedge clk) disable iff (rst)
        flt_i.uv_aux |=> !aux_en_o);

    // R9
    uv_main_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((flt_i.uv_p3 || flt_i.uv_p15) && !flt_i.test_strap) |=> !main_en_o);

endmodule

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl
    import slot_pwr_pkg::*;
#(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_active_i,
    input  logic pcie_present_n_i,
    input  logic usb_present_n_i,
    input  logic master_en_i,
    input  logic test_strap_i,
    input  logic uv_aux_i,
    input  logic uv_p3_i,
    input  logic uv_p15_i,
    input  logic over_temp_i,
    output logic aux_en_o,
    output logic main_en_o,
    output logic aux_dis_o,
    output logic main_dis_o
);
    ctl_t        raw_ctl, clean_ctl;
    fault_t      flt;
    slot_state_e slot_st;

    assign raw_ctl = '{sys_up: sys_active_i, pcie_n: pcie_present_n_i,
                       usb_n: usb_present_n_i, enable: master_en_i};
    assign flt     = '{uv_aux: uv_aux_i, uv_p3: uv_p3_i, uv_p15: uv_p15_i,
                       hot: over_temp_i, test_strap: test_strap_i};

    input_cond #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (raw_ctl),
        .clean_o (clean_ctl)
    );

    slot_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (clean_ctl),
        .state_o (slot_st)
    );

    rail_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .state_i    (slot_st),
        .flt_i      (flt),
        .aux_en_o   (aux_en_o),
        .main_en_o  (main_en_o),
        .aux_dis_o  (aux_dis_o),
        .main_dis_o (main_dis_o)
    );

endmodule

// File: tb/slot_pwr_ctrl_tb_top.sv
module slot_pwr_ctrl_tb_top;
    localparam int DEB = 4;
    localparam int SETTLE = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_act = 1'b0, pcie_n = 1'b1, usb_n = 1'b1, en = 1'b0;
    logic test = 1'b0, uva = 1'b0, uv3 = 1'b0, uv15 = 1'b0, hot = 1'b0;
    logic aux_en, main_en, aux_dis, main_dis;

    int checks = 0;
    int errors = 0;

    // reference model state: card was powered while active and is still in
    bit keep = 1'b0;

    always #4 clk = ~clk;

    slot_pwr_ctrl #(.DEB_CYCLES(DEB)) dut_i (
        .clk(clk), .rst(rst),
        .sys_active_i(sys_act), .pcie_present_n_i(pcie_n), .usb_present_n_i(usb_n),
        .master_en_i(en), .test_strap_i(test), .uv_aux_i(uva), .uv_p3_i(uv3),
        .uv_p15_i(uv15), .over_temp_i(hot),
        .aux_en_o(aux_en), .main_en_o(main_en), .aux_dis_o(aux_dis), .main_dis_o(main_dis)
    );

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(string tag, bit exp_aux, bit exp_main);
        checks++;
        if (aux_en !== exp_aux || main_en !== exp_main ||
            aux_dis !== !exp_aux || main_dis !== !exp_main) begin
            errors++;
            $display("FAIL %s: got aux=%b main=%b auxdis=%b maindis=%b, exp aux=%b main=%b auxdis=%b maindis=%b",
                     tag, aux_en, main_en, aux_dis, main_dis, exp_aux, exp_main, !exp_aux, !exp_main);
        end
    endtask

    function automatic bit card_now();
        return !pcie_n || !usb_n;
    endfunction

    function automatic bit exp_aux_f();
        return en && card_now() && (sys_act || keep) && !uva && !hot;
    endfunction

    function automatic bit exp_main_f();
        return en && sys_act && card_now() && !hot && !((uv3 || uv15) && !test);
    endfunction

    // update the history after new stable control levels
    task automatic model_step();
        if (!en)          keep = 1'b0;
        else if (sys_act) keep = card_now();
        else              keep = keep && card_now();
    endtask

    task automatic apply(bit e, bit a, bit pn, bit un);
        en = e; sys_act = a; pcie_n = pn; usb_n = un;
        model_step();
        wait_neg(SETTLE);
    endtask

    task automatic check_model(string tag);
        check(tag, exp_aux_f(), exp_main_f());
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        wait_neg(3);
        check("R1 reset state", 1'b0, 1'b0);
        rst = 1'b0;
        wait_neg(2);
        check("R1 after reset release", 1'b0, 1'b0);

        apply(1, 1, 1, 1);   check("R2 active no card", 0, 0);
        apply(1, 1, 1, 0);   check("R3 usb card active", 1, 1);
        apply(1, 1, 0, 1);   check("R2 pcie pin alone counts", 1, 1);
        apply(1, 1, 0, 0);   check("R3 both pins", 1, 1);
        apply(1, 0, 0, 1);   check("R4 standby keeps aux", 1, 0);
        apply(1, 0, 1, 1);   check("R6 removal in standby", 0, 0);
        apply(1, 0, 0, 1);   check("R6 reinsert in standby", 0, 0);
        apply(1, 1, 0, 1);   check("R12 back to active", 1, 1);
        apply(1, 0, 1, 1);   check("R2 standby no card", 0, 0);
        apply(1, 0, 1, 0);   check("R5 insert during standby", 0, 0);
        apply(1, 1, 1, 0);   check("R12 active after dark", 1, 1);
        apply(0, 1, 1, 0);   check("R7 master disable", 0, 0);
        apply(1, 0, 1, 0);   check("R5 enable in standby with card", 0, 0);
        apply(1, 1, 1, 0);   check("R3 on again", 1, 1);

        // R11 glitch shorter than DEB on system status
        sys_act = 1'b0; wait_neg(2); sys_act = 1'b1;
        wait_neg(SETTLE);
        check("R11 glitch filtered", 1, 1);

        // R11 latency: old value after 5 clocks, new value later
        sys_act = 1'b0;
        wait_neg(5);
        check("R11 not yet settled", 1, 1);
        model_step();
        wait_neg(SETTLE);
        check("R11 settled to standby", 1, 0);

        apply(1, 1, 1, 0);
        uva = 1'b1; wait_neg(3);  check("R8 aux uv", 0, 1);
        uva = 1'b0; uv3 = 1'b1; wait_neg(3); check("R9 uv p3", 1, 0);
        uv3 = 1'b0; uv15 = 1'b1; wait_neg(3); check("R9 uv p15", 1, 0);
        test = 1'b1; uv3 = 1'b1; wait_neg(3); check("R9 strap ignores uv", 1, 1);
        hot = 1'b1; wait_neg(3); check("R10 thermal", 0, 0);
        hot = 1'b0; uv3 = 1'b0; uv15 = 1'b0; test = 1'b0; wait_neg(3);
        check("R8 faults cleared", 1, 1);

        // random sequences, fixed seed
        void'($urandom(32'h5107_c0de));
        for (int i = 0; i < 200; i++) begin
            test = ($urandom_range(0, 9) < 3);
            uva  = ($urandom_range(0, 9) == 0);
            uv3  = ($urandom_range(0, 9) == 0);
            uv15 = ($urandom_range(0, 9) == 0);
            hot  = ($urandom_range(0, 19) == 0);
            apply(($urandom_range(0, 99) < 88), $urandom_range(0, 1),
                  $urandom_range(0, 1), ($urandom_range(0, 2) != 0));
            check_model("R3 R4 R5 R6 R7 R8 R9 R10 R12 random");
        end

        finish_run();
    end

endmodule